// File: doc/BRIEF.md
# Command Ring Doorbell Engine

This block sits between host software and a storage channel. Each port owns two circular rings of descriptors, one for requests and one for responses, each with 32 slots. Software places work in the request ring and rings a doorbell by advancing the request in-pointer. The port engine takes pending slots one at a time. For each slot it waits for a descriptor fetch stub with fixed latency, writes a completion entry into the response ring, advances the response in-pointer and sets that port's bit in a shared completion cause register. Software then retires completions by reading the entry at the response out-pointer and advancing that pointer.

All state is reached through a small register interface. Reads and writes last one cycle, and read data is registered. The address is split into two parts: a port select in the upper bits and a 3-bit register select in bits 2:0. The register selects are: 0 command/status, 1 request in-pointer, 2 request out-pointer, 3 response in-pointer, 4 response out-pointer, 5 completion cause (shared by all ports, so the port select is ignored), 6 completion entry at the response out-pointer. Each ring index sits in a shifted field inside a 32-bit pointer word. The other bits of the word hold a base address that the engine carries along but never changes.

Top module: `cmdring_engine`

## Requirements
- R1: After the synchronous reset, every pointer register, every command/status register and the cause register read back as zero.
- R2: While a port is disabled, a pointer write stores the whole 32-bit word. The request pointers hold their index in bits 9:5 and the response pointers hold theirs in bits 7:3.
- R3: While a port is enabled, a pointer write changes only that pointer's index field and keeps its other bits.
- R4: An enabled port serves every slot between the request out-pointer and the request in-pointer. For each slot it advances the request out-pointer and the response in-pointer by one, and both indices wrap modulo 32.
- R5: The completion entry written for a request holds that request's slot index. Reading register 6 returns it, zero-extended, for the entry at the response out-pointer.
- R6: Each completion sets the cause bit of its port (bit 0 for port 0, bit 1 for port 1) one cycle later. Writing 0 to a cause bit clears it, and writing 1 leaves it unchanged.
- R7: When the response ring is full (response in-index plus one equals response out-index), the port stalls without writing an entry. It resumes when software advances the response out-pointer.
- R8: A port has at most one fetch in flight. A new fetch starts only after the previous completion entry has been written.
- R9: A disabled port does not consume requests, however the request in-pointer is changed.
- R10: Command bit 1 requests a disable. Status bit 1 shows the request as pending until the in-flight command finishes, after which both bit 1 and the enable status (bit 0) read zero. Command bit 0 enables the port.
- R11: Writing command bit 2 as 1 and then as 0 leaves all four pointer registers and the enable status at zero.
- R12: Read data and its valid flag appear on the cycle after a read strobe. The valid flag is low on cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Port select in the upper bits, register select in bits 2:0 |
| wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | High on the cycle that carries read data |
| cause_o | output | NPORTS | Per-port completion cause bits |

## Verification
Faults in this block become visible through its pointer registers and cause bits.

- **Wrong index arithmetic or a missed wrap.** The request out-pointer and the response in-pointer leave lockstep. This shows on the first read after the next doorbell, for example after a batch that crosses slot 31.
- **Full test computed wrongly.** The full-ring scenario shows it at once. Either the out-pointer moves past a slot it must hold at, or it stays stuck after software frees space.
- **Lost disable or reset state.** The status register returns a non-zero enable, or a doorbell is consumed while the port should be disabled. Both show within a few fetch latencies of the command write.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } eng_state_t;

  typedef enum logic [2:0] {
    RG_CMD      = 3'd0,
    RG_REQ_IN   = 3'd1,
    RG_REQ_OUT  = 3'd2,
    RG_RSP_IN   = 3'd3,
    RG_RSP_OUT  = 3'd4,
    RG_CAUSE    = 3'd5,
    RG_RSP_DATA = 3'd6
  } reg_sel_t;

  localparam int CMD_EN_BIT  = 0;
  localparam int CMD_DIS_BIT = 1;
  localparam int CMD_RST_BIT = 2;

endpackage

// File: rtl/cmdring_fetch_stub.sv
module cmdring_fetch_stub #(
  parameter int LATENCY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic abort,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(LATENCY + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(LATENCY);
      end else if (busy_q) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/cmdring_rsp_ram.sv
module cmdring_rsp_ram #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 5
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cmdring_port.sv
module cmdring_port
  import cmdring_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int DATA_W    = 32,
  parameter int REQ_LSB   = 5,
  parameter int RSP_LSB   = 3,
  parameter int FETCH_LAT = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_cmd,
  input  logic                     wr_req_in,
  input  logic                     wr_req_out,
  input  logic                     wr_rsp_in,
  input  logic                     wr_rsp_out,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        req_in_o,
  output logic [DATA_W-1:0]        req_out_o,
  output logic [DATA_W-1:0]        rsp_in_o,
  output logic [DATA_W-1:0]        rsp_out_o,
  output logic [2:0]               status_o,
  output logic [$clog2(DEPTH)-1:0] head_o,
  output logic                     complete_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [DATA_W-1:0] FIELD    = DATA_W'((1 << IDX_W) - 1);
  localparam logic [DATA_W-1:0] REQ_MASK = FIELD << REQ_LSB;
  localparam logic [DATA_W-1:0] RSP_MASK = FIELD << RSP_LSB;
  localparam logic [DATA_W-1:0] REQ_ONE  = DATA_W'(1) << REQ_LSB;
  localparam logic [DATA_W-1:0] RSP_ONE  = DATA_W'(1) << RSP_LSB;

  function automatic logic [DATA_W-1:0] host_write(
    input logic [DATA_W-1:0] old_v,
    input logic [DATA_W-1:0] new_v,
    input logic [DATA_W-1:0] mask,
    input logic              field_only
  );
    return field_only ? ((old_v & ~mask) | (new_v & mask)) : new_v;
  endfunction

  function automatic logic [DATA_W-1:0] step_idx(
    input logic [DATA_W-1:0] old_v,
    input logic [DATA_W-1:0] mask,
    input logic [DATA_W-1:0] one
  );
    logic [DATA_W-1:0] inc;
    inc = (old_v & mask) + one;
    return (old_v & ~mask) | (inc & mask);
  endfunction

  eng_state_t        state_q;
  logic              en_q, dis_q, crst_q;
  logic [DATA_W-1:0] req_in_q, req_out_q, rsp_in_q, rsp_out_q;
  logic [IDX_W-1:0]  req_in_idx, req_out_idx, rsp_in_idx, rsp_out_idx;
  logic              rsp_full, pending, start_fetch, complete, clear_all;
  logic              fetch_busy, fetch_done;

  assign req_in_idx  = req_in_q[REQ_LSB +: IDX_W];
  assign req_out_idx = req_out_q[REQ_LSB +: IDX_W];
  assign rsp_in_idx  = rsp_in_q[RSP_LSB +: IDX_W];
  assign rsp_out_idx = rsp_out_q[RSP_LSB +: IDX_W];

  assign rsp_full    = (rsp_in_idx + IDX_W'(1)) == rsp_out_idx;
  assign pending     = req_in_idx != req_out_idx;
  assign clear_all   = rst || crst_q;
  assign start_fetch = (state_q == ST_IDLE) && en_q && !dis_q && !crst_q
                       && pending && !rsp_full;
  assign complete    = (state_q == ST_FETCH) && fetch_done && !crst_q;

  // Command and status: enable, pending disable, channel reset level
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      dis_q  <= 1'b0;
      crst_q <= 1'b0;
    end else if (wr_cmd) begin
      crst_q <= wdata[CMD_RST_BIT];
      if (wdata[CMD_RST_BIT] || crst_q) begin
        en_q  <= 1'b0;
        dis_q <= 1'b0;
      end else if (wdata[CMD_DIS_BIT]) begin
        dis_q <= en_q;
      end else if (wdata[CMD_EN_BIT]) begin
        en_q <= 1'b1;
      end
    end else if (crst_q) begin
      en_q  <= 1'b0;
      dis_q <= 1'b0;
    end else if (dis_q && state_q == ST_IDLE) begin
      en_q  <= 1'b0;
      dis_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (clear_all)        state_q <= ST_IDLE;
    else if (start_fetch) state_q <= ST_FETCH;
    else if (complete)    state_q <= ST_IDLE;
  end

  // Pointer words: engine advance wins over a host write in the same cycle
  always_ff @(posedge clk) begin
    if (clear_all) begin
      req_in_q  <= '0;
      req_out_q <= '0;
      rsp_in_q  <= '0;
      rsp_out_q <= '0;
    end else begin
      if (wr_req_in)
        req_in_q <= host_write(req_in_q, wdata, REQ_MASK, en_q);
      if (complete)
        req_out_q <= step_idx(req_out_q, REQ_MASK, REQ_ONE);
      else if (wr_req_out)
        req_out_q <= host_write(req_out_q, wdata, REQ_MASK, en_q);
      if (complete)
        rsp_in_q <= step_idx(rsp_in_q, RSP_MASK, RSP_ONE);
      else if (wr_rsp_in)
        rsp_in_q <= host_write(rsp_in_q, wdata, RSP_MASK, en_q);
      if (wr_rsp_out)
        rsp_out_q <= host_write(rsp_out_q, wdata, RSP_MASK, en_q);
    end
  end

  cmdring_fetch_stub #(.LATENCY(FETCH_LAT)) fetch_i (
    .clk   (clk),
    .rst   (rst),
    .abort (crst_q),
    .start (start_fetch),
    .busy  (fetch_busy),
    .done  (fetch_done)
  );

  cmdring_rsp_ram #(.DEPTH(DEPTH), .WIDTH(IDX_W)) ram_i (
    .clk   (clk),
    .we    (complete),
    .waddr (rsp_in_idx),
    .wdata (req_out_idx),
    .raddr (rsp_out_idx),
    .rdata (head_o)
  );

  assign req_in_o   = req_in_q;
  assign req_out_o  = req_out_q;
  assign rsp_in_o   = rsp_in_q;
  assign rsp_out_o  = rsp_out_q;
  assign status_o   = {crst_q, dis_q, en_q};
  assign complete_o = complete;

  assert_fetch_serial_R8: assert property (@(posedge clk) disable iff (rst)
    start_fetch |-> !fetch_busy);

  assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (rst)
    complete |-> !rsp_full);

  assert_lockstep_R4: assert property (@(posedge clk) disable iff (rst)
    complete |=> (req_out_idx == $past(req_out_idx) + IDX_W'(1)));

  assert_disable_drops_R10: assert property (@(posedge clk) disable iff (rst || wr_cmd)
    (dis_q && state_q == ST_IDLE) |=> !en_q);

  assert_reset_zero_R11: assert property (@(posedge clk) disable iff (rst)
    crst_q |=> (req_in_q == '0 && req_out_q == '0 && rsp_in_q == '0
                && rsp_out_q == '0 && !en_q));
endmodule

// File: rtl/cmdring_engine.sv
module cmdring_engine
  import cmdring_pkg::*;
#(
  parameter int NPORTS    = 2,
  parameter int DEPTH     = 32,
  parameter int DATA_W    = 32,
  parameter int REQ_LSB   = 5,
  parameter int RSP_LSB   = 3,
  parameter int FETCH_LAT = 4,
  parameter int PSEL_W    = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  parameter int ADDR_W    = PSEL_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [NPORTS-1:0] cause_o
);
  localparam int IDX_W = $clog2(DEPTH);

  reg_sel_t          rsel;
  logic [PSEL_W-1:0] psel;
  logic              psel_ok;

  logic [NPORTS-1:0][DATA_W-1:0] req_in_a, req_out_a, rsp_in_a, rsp_out_a;
  logic [NPORTS-1:0][2:0]        status_a;
  logic [NPORTS-1:0][IDX_W-1:0]  head_a;
  logic [NPORTS-1:0]             complete_a;

  logic [NPORTS-1:0] cause_q;
  logic [DATA_W-1:0] rd_data_q, rd_mux;
  logic              rd_valid_q;

  assign rsel    = reg_sel_t'(addr[2:0]);
  assign psel    = addr[ADDR_W-1:3];
  assign psel_ok = int'(psel) < NPORTS;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic hit;
    assign hit = wr_en && (psel == PSEL_W'(p));

    cmdring_port #(
      .DEPTH(DEPTH), .DATA_W(DATA_W), .REQ_LSB(REQ_LSB),
      .RSP_LSB(RSP_LSB), .FETCH_LAT(FETCH_LAT)
    ) port_i (
      .clk        (clk),
      .rst        (rst),
      .wr_cmd     (hit && rsel == RG_CMD),
      .wr_req_in  (hit && rsel == RG_REQ_IN),
      .wr_req_out (hit && rsel == RG_REQ_OUT),
      .wr_rsp_in  (hit && rsel == RG_RSP_IN),
      .wr_rsp_out (hit && rsel == RG_RSP_OUT),
      .wdata      (wdata),
      .req_in_o   (req_in_a[p]),
      .req_out_o  (req_out_a[p]),
      .rsp_in_o   (rsp_in_a[p]),
      .rsp_out_o  (rsp_out_a[p]),
      .status_o   (status_a[p]),
      .head_o     (head_a[p]),
      .complete_o (complete_a[p])
    );

    assert_cause_set_R6: assert property (@(posedge clk) disable iff (rst)
      complete_a[p] |=> cause_o[p]);
  end

  // Shared cause register: set by a completion, cleared by writing zero
  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
    end else begin
      for (int p = 0; p < NPORTS; p++) begin
        if (complete_a[p])
          cause_q[p] <= 1'b1;
        else if (wr_en && rsel == RG_CAUSE && !wdata[p])
          cause_q[p] <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rsel == RG_CAUSE) begin
      rd_mux = DATA_W'(cause_q);
    end else if (psel_ok) begin
      case (rsel)
        RG_CMD:      rd_mux = DATA_W'(status_a[psel]);
        RG_REQ_IN:   rd_mux = req_in_a[psel];
        RG_REQ_OUT:  rd_mux = req_out_a[psel];
        RG_RSP_IN:   rd_mux = rsp_in_a[psel];
        RG_RSP_OUT:  rd_mux = rsp_out_a[psel];
        RG_RSP_DATA: rd_mux = DATA_W'(head_a[psel]);
        default:     rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) rd_data_q <= rd_mux;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;
  assign cause_o  = cause_q;

  assert_read_latency_R12: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
endmodule

// File: tb/cmdring_engine_tb_top.sv
module cmdring_engine_tb_top;
  localparam int LAT = 4;
  localparam int STEP = LAT + 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [1:0]  cause_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  int exp_req [2];
  int exp_rin [2];
  int exp_rout[2];
  logic [31:0] breq[2];
  logic [31:0] brsp[2];

  always #10 clk = ~clk;

  cmdring_engine #(.FETCH_LAT(LAT)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid), .cause_o(cause_o)
  );

  function automatic logic [31:0] req_w(logic [31:0] base, int idx);
    return (base & ~32'h0000_03E0) | (32'(idx % 32) << 5);
  endfunction

  function automatic logic [31:0] rsp_w(logic [31:0] base, int idx);
    return (base & ~32'h0000_00F8) | (32'(idx % 32) << 3);
  endfunction

  function automatic logic [3:0] ra(int p, int r);
    return 4'(p * 8 + r);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_reg(string req, logic [3:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  // R5: read each completion entry and retire it
  task automatic drain(int p, int n);
    for (int k = 0; k < n; k++) begin
      idle(3);
      expect_reg("R5 entry", ra(p, 6), 32'(exp_rout[p] % 32));
      exp_rout[p] = (exp_rout[p] + 1) % 32;
      wr(ra(p, 4), rsp_w(brsp[p], exp_rout[p]));
    end
    idle(3);
  endtask

  task automatic doorbell(int p, int n);
    exp_req[p] = (exp_req[p] + n) % 32;
    wr(ra(p, 1), req_w(breq[p], exp_req[p]));
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    idle(4);
    rst = 1'b0;
    idle(2);

    // R1: reset state
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 5; r++)
        expect_reg("R1 reset", ra(p, r), 32'h0);
    expect_reg("R1 cause", ra(0, 5), 32'h0);

    // R12: valid flag with read timing
    @(negedge clk); addr = ra(0, 1); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check("R12 valid after read", 32'(rd_valid), 32'h1);
    @(negedge clk);
    check("R12 valid idle", 32'(rd_valid), 32'h0);

    // R2: full-word writes while disabled
    breq[0] = 32'hA5A0_0C00; brsp[0] = 32'h0C30_0500;
    breq[1] = 32'h1230_1000; brsp[1] = 32'h0770_0200;
    for (int p = 0; p < 2; p++) begin
      exp_req[p] = 0; exp_rin[p] = 0; exp_rout[p] = 0;
      wr(ra(p, 1), req_w(breq[p], 0));
      wr(ra(p, 2), req_w(breq[p], 0));
      wr(ra(p, 3), rsp_w(brsp[p], 0));
      wr(ra(p, 4), rsp_w(brsp[p], 0));
      expect_reg("R2 req_in", ra(p, 1), req_w(breq[p], 0));
      expect_reg("R2 rsp_out", ra(p, 4), rsp_w(brsp[p], 0));
    end
    wr(ra(0, 1), req_w(breq[0], 7));
    expect_reg("R2 req index field", ra(0, 1), breq[0] | 32'h0000_00E0);
    wr(ra(0, 1), req_w(breq[0], 0));

    // R9: disabled port ignores doorbell
    doorbell(0, 2);
    idle(40);
    expect_reg("R9 disabled no consume", ra(0, 2), req_w(breq[0], 0));

    // R10: enable
    wr(ra(0, 0), 32'h1);
    wr(ra(1, 0), 32'h1);
    expect_reg("R10 enable status", ra(0, 0), 32'h1);
    idle(2 * STEP + 10);
    expect_reg("R4 req_out", ra(0, 2), req_w(breq[0], 2));
    exp_rin[0] = 2;
    expect_reg("R4 rsp_in", ra(0, 3), rsp_w(brsp[0], 2));
    drain(0, 2);

    // R3: enabled write keeps non-index bits
    wr(ra(0, 1), 32'h5555_0000 | (32'(exp_req[0]) << 5));
    expect_reg("R3 keep upper", ra(0, 1), req_w(breq[0], exp_req[0]));

    // Random batches
    for (int it = 0; it < 24; it++) begin
      int p, n;
      p = int'($urandom_range(1, 0));
      n = int'($urandom_range(6, 1));
      doorbell(p, n);
      idle(n * STEP + 10);
      exp_rin[p] = (exp_rin[p] + n) % 32;
      expect_reg("R4 req_out", ra(p, 2), req_w(breq[p], exp_req[p]));
      expect_reg("R4 rsp_in", ra(p, 3), rsp_w(brsp[p], exp_rin[p]));
      rd(ra(0, 5), v);
      check("R6 cause set", 32'(v[p]), 32'h1);
      wr(ra(0, 5), ~(32'h1 << p));
      rd(ra(0, 5), v);
      check("R6 cause cleared", 32'(v[p]), 32'h0);
      drain(p, n);
    end

    // R6: writing one keeps a set bit
    doorbell(0, 1);
    idle(STEP + 10);
    exp_rin[0] = (exp_rin[0] + 1) % 32;
    wr(ra(0, 5), 32'h1);
    rd(ra(0, 5), v);
    check("R6 write one keeps", 32'(v[0]), 32'h1);
    check("R6 cause port", 32'(cause_o[0]), 32'h1);
    wr(ra(0, 5), 32'h0);
    check("R6 cleared pin", 32'(cause_o), 32'h0);
    drain(0, 1);

    // R10: disable during an in-flight command
    doorbell(0, 1);
    wr(ra(0, 0), 32'h2);
    rd(ra(0, 0), v);
    check("R10 disable pending", v & 32'h2, 32'h2);
    idle(STEP + 10);
    exp_rin[0] = (exp_rin[0] + 1) % 32;
    expect_reg("R10 status dropped", ra(0, 0), 32'h0);
    expect_reg("R10 in-flight done", ra(0, 2), req_w(breq[0], exp_req[0]));
    drain(0, 1);
    doorbell(0, 3);
    idle(3 * STEP + 10);
    expect_reg("R9 disabled holds", ra(0, 2), req_w(breq[0], exp_req[0] - 3 + 32));
    wr(ra(0, 0), 32'h1);
    idle(3 * STEP + 10);
    exp_rin[0] = (exp_rin[0] + 3) % 32;
    expect_reg("R4 resume", ra(0, 2), req_w(breq[0], exp_req[0]));
    drain(0, 3);

    // R11: channel reset on port 1
    wr(ra(1, 0), 32'h4);
    wr(ra(1, 0), 32'h0);
    for (int r = 0; r < 5; r++)
      expect_reg("R11 cleared", ra(1, r), 32'h0);

    // R7: full ring stall and wrap on port 1
    breq[1] = '0; brsp[1] = '0;
    wr(ra(1, 0), 32'h1);
    wr(ra(1, 1), req_w(0, 31));
    idle(31 * STEP + 20);
    expect_reg("R4 fill req_out", ra(1, 2), req_w(0, 31));
    expect_reg("R7 ring full rsp_in", ra(1, 3), rsp_w(0, 31));
    wr(ra(1, 1), req_w(0, 3));
    idle(4 * STEP + 10);
    expect_reg("R7 stalled", ra(1, 2), req_w(0, 31));
    wr(ra(1, 4), rsp_w(0, 2));
    idle(4 * STEP + 10);
    expect_reg("R7 resume partial", ra(1, 2), req_w(0, 1));
    expect_reg("R7 rsp_in wrap", ra(1, 3), rsp_w(0, 1));
    wr(ra(1, 4), rsp_w(0, 10));
    idle(4 * STEP + 10);
    expect_reg("R4 wrap req_out", ra(1, 2), req_w(0, 3));
    expect_reg("R4 wrap rsp_in", ra(1, 3), rsp_w(0, 3));
    idle(3);
    expect_reg("R5 old entry", ra(1, 6), 32'd10);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule